// File: doc/BRIEF.md
# In-Order Retirement Queue with Precise Exceptions

This block sits between decode and the architectural register file of an out-of-order core. Decode reserves one slot per instruction, in program order, and gets back the slot index. Each slot records the instruction's address, its kind and its destination register. Execution units finish in any order. They report a finished instruction by its slot index, together with its result and an exception flag with a cause code. The result and the exception flag stay in the slot until that slot becomes the oldest one in the queue.

Only the oldest slot can retire, and at most one slot retires per cycle. A slot that finished cleanly writes its result to the register file if its kind produces one. A slot that finished with an exception raises a trap instead. The trap kills that slot and every younger slot in the same cycle, and it sends fetch to a fixed handler address. Because the exception is acted on only when the slot reaches the head, every older instruction has already retired and no younger one has changed state, so the trap is precise.

A combinational lookup port lets a dependent instruction read a result that has finished but not yet retired. The port searches only slots older than the requester.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `retire_valid`, `rf_we` and `trap_valid` are 0.
- R2: Accepted allocations receive consecutive slot indices in program order, wrapping modulo DEPTH.
- R3: Once DEPTH slots are occupied, `alloc_ready` is 0 and a request on `alloc_valid` is ignored.
- R4: A completion writes the result, exception flag and cause into the slot named by `cpl_idx`, and the slot holds them until it retires or is flushed.
- R5: Only the oldest slot may retire, and only after it has completed; a completed younger slot waits and produces no retirement.
- R6: A clean retirement raises `retire_valid`. It also raises `rf_we` with the slot's destination and result when the kind code is 0 (arith) or 1 (load). Kind codes 2 (store) and 3 (branch) retire with `rf_we` at 0.
- R7: When the oldest slot has completed with an exception, `trap_valid` is 1 for exactly one cycle, carrying that slot's address and cause. `redirect_pc` equals TRAP_VECTOR, and `rf_we` and `retire_valid` are 0. An exception on a slot that is not the oldest raises no trap.
- R8: A trap empties the queue in the same cycle. The next allocation receives the faulting slot's index, the full DEPTH slots are available again, and no killed slot ever retires.
- R9: The lookup returns the youngest slot that writes `fwd_src` and is older than `fwd_req_idx`. It reports a hit with that slot's result only if the slot has completed without an exception.
- R10: The lookup reports a miss when no older slot writes `fwd_src`. Slots at or younger than the requester, and store or branch slots, are never matched.
- R11: Retirement advances the head by exactly one slot per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_pc | input | PC_W | Instruction address |
| alloc_kind | input | 2 | Kind: 0 arith, 1 load, 2 store, 3 branch |
| alloc_dst | input | log2(NREG) | Destination register |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_idx | output | log2(DEPTH) | Index the next slot will receive |
| cpl_valid | input | 1 | An execution unit reports a finished slot |
| cpl_idx | input | log2(DEPTH) | Finished slot index |
| cpl_value | input | XLEN | Result |
| cpl_exc | input | 1 | Slot raised an exception |
| cpl_cause | input | CAUSE_W | Exception cause |
| fwd_src | input | log2(NREG) | Register the dependent wants |
| fwd_req_idx | input | log2(DEPTH) | Slot index of the dependent |
| fwd_hit | output | 1 | A finished, uncommitted value was found |
| fwd_value | output | XLEN | The forwarded value |
| rf_we | output | 1 | Architectural register write enable |
| rf_waddr | output | log2(NREG) | Write register |
| rf_wdata | output | XLEN | Write data |
| retire_valid | output | 1 | The oldest slot retires cleanly this cycle |
| trap_valid | output | 1 | The oldest slot traps this cycle |
| trap_pc | output | PC_W | Address of the faulting instruction |
| trap_cause | output | CAUSE_W | Cause of the faulting instruction |
| redirect_pc | output | PC_W | Handler address for fetch |

## Verification
Two situations are hard to reach from the ports. The first is a queue that is completely full while every slot except the oldest has finished, so that younger finished results must wait behind an unfinished head. The bench fills all slots, completes them in reverse order, and runs the lookup checks in that state before it finally releases the head. The second is an exception on a slot that is not yet the oldest. The bench records that exception first, lets the older slot retire, and only then expects the trap. It then confirms that the queue is fully empty again by refilling every slot.

// File: rtl/rq_pkg.sv
package rq_pkg;
    typedef enum logic [1:0] {
        K_ARITH  = 2'd0,
        K_LOAD   = 2'd1,
        K_STORE  = 2'd2,
        K_BRANCH = 2'd3
    } kind_e;

    function automatic logic kind_writes_reg(kind_e k);
        return (k == K_ARITH) || (k == K_LOAD);
    endfunction
endpackage

// File: rtl/rq_fwd.sv
module rq_fwd #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int RW    = 5,
    parameter int XLEN  = 32
) (
    input  logic [AW-1:0]                 head_idx,
    input  logic [DEPTH-1:0]              ent_valid,
    input  logic [DEPTH-1:0]              ent_wr,
    input  logic [DEPTH-1:0]              ent_done,
    input  logic [DEPTH-1:0]              ent_exc,
    input  logic [DEPTH-1:0][RW-1:0]      ent_dst,
    input  logic [DEPTH-1:0][XLEN-1:0]    ent_value,
    input  logic [RW-1:0]                 src,
    input  logic [AW-1:0]                 req_idx,
    output logic                          hit,
    output logic [XLEN-1:0]               value
);
    logic [AW-1:0]    req_off;
    logic [DEPTH-1:0] match;
    logic             found;
    logic [AW-1:0]    sel;

    assign req_off = req_idx - head_idx;

    // Per-slot candidate: live, writes a register, same register, older than requester
    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        logic [AW-1:0] off;
        assign off      = AW'(g) - head_idx;
        assign match[g] = ent_valid[g] && ent_wr[g] && (ent_dst[g] == src) && (off < req_off);
    end

    // Scan from oldest to youngest; the last match is the youngest older producer
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [AW-1:0] idx;
            idx = head_idx + AW'(k);
            if (match[idx]) begin
                found = 1'b1;
                sel   = idx;
            end
        end
    end

    assign hit   = found && ent_done[sel] && !ent_exc[sel];
    assign value = hit ? ent_value[sel] : '0;
endmodule

// File: rtl/rq_retire.sv
module rq_retire
    import rq_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int PC_W    = 32,
    parameter int RW      = 5,
    parameter int CAUSE_W = 4
) (
    input  logic               head_valid,
    input  logic               head_done,
    input  logic               head_exc,
    input  kind_e              head_kind,
    input  logic [RW-1:0]      head_dst,
    input  logic [XLEN-1:0]    head_value,
    input  logic [PC_W-1:0]    head_pc,
    input  logic [CAUSE_W-1:0] head_cause,
    output logic               commit_ok,
    output logic               trap,
    output logic               rf_we,
    output logic [RW-1:0]      rf_waddr,
    output logic [XLEN-1:0]    rf_wdata,
    output logic [PC_W-1:0]    trap_pc,
    output logic [CAUSE_W-1:0] trap_cause
);
    logic ready;

    assign ready      = head_valid && head_done;
    assign commit_ok  = ready && !head_exc;
    assign trap       = ready && head_exc;
    assign rf_we      = commit_ok && kind_writes_reg(head_kind);
    assign rf_waddr   = head_dst;
    assign rf_wdata   = head_value;
    assign trap_pc    = head_pc;
    assign trap_cause = head_cause;
endmodule

// File: rtl/retire_queue.sv
module retire_queue
    import rq_pkg::*;
#(
    parameter int                     DEPTH       = 8,
    parameter int                     XLEN        = 32,
    parameter int                     PC_W        = 32,
    parameter int                     NREG        = 32,
    parameter int                     CAUSE_W     = 4,
    parameter logic [PC_W-1:0]        TRAP_VECTOR = 32'h0000_0100,
    localparam int                    AW          = $clog2(DEPTH),
    localparam int                    RW          = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [PC_W-1:0]    alloc_pc,
    input  logic [1:0]         alloc_kind,
    input  logic [RW-1:0]      alloc_dst,
    output logic               alloc_ready,
    output logic [AW-1:0]      alloc_idx,
    input  logic               cpl_valid,
    input  logic [AW-1:0]      cpl_idx,
    input  logic [XLEN-1:0]    cpl_value,
    input  logic               cpl_exc,
    input  logic [CAUSE_W-1:0] cpl_cause,
    input  logic [RW-1:0]      fwd_src,
    input  logic [AW-1:0]      fwd_req_idx,
    output logic               fwd_hit,
    output logic [XLEN-1:0]    fwd_value,
    output logic               rf_we,
    output logic [RW-1:0]      rf_waddr,
    output logic [XLEN-1:0]    rf_wdata,
    output logic               retire_valid,
    output logic               trap_valid,
    output logic [PC_W-1:0]    trap_pc,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [PC_W-1:0]    redirect_pc
);
    localparam logic [AW:0] FULL_COUNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic               valid;
        logic               done;
        logic               exc;
        kind_e              kind;
        logic [RW-1:0]      dst;
        logic [XLEN-1:0]    value;
        logic [PC_W-1:0]    pc;
        logic [CAUSE_W-1:0] cause;
    } slot_t;

    typedef struct packed {
        logic [AW:0]             head;
        logic [AW:0]             tail;
        slot_t [DEPTH-1:0]       slot;
    } state_t;

    state_t st_d, st_q;

    logic [AW:0]   count_q;
    logic          full_q;
    logic [AW-1:0] head_idx;
    logic [AW-1:0] tail_idx;
    slot_t         head_slot;
    logic          commit_ok;
    logic          trap;
    logic          take;

    assign count_q   = st_q.tail - st_q.head;
    assign full_q    = (count_q == FULL_COUNT);
    assign head_idx  = st_q.head[AW-1:0];
    assign tail_idx  = st_q.tail[AW-1:0];
    assign head_slot = st_q.slot[head_idx];

    // Head decision: clean retire or precise trap
    rq_retire #(
        .XLEN(XLEN), .PC_W(PC_W), .RW(RW), .CAUSE_W(CAUSE_W)
    ) u_retire (
        .head_valid (head_slot.valid),
        .head_done  (head_slot.done),
        .head_exc   (head_slot.exc),
        .head_kind  (head_slot.kind),
        .head_dst   (head_slot.dst),
        .head_value (head_slot.value),
        .head_pc    (head_slot.pc),
        .head_cause (head_slot.cause),
        .commit_ok  (commit_ok),
        .trap       (trap),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .trap_pc    (trap_pc),
        .trap_cause (trap_cause)
    );

    // Forwarding search over uncommitted slots
    logic [DEPTH-1:0]           v_vec, wr_vec, done_vec, exc_vec;
    logic [DEPTH-1:0][RW-1:0]   dst_vec;
    logic [DEPTH-1:0][XLEN-1:0] val_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign v_vec[g]    = st_q.slot[g].valid;
        assign wr_vec[g]   = kind_writes_reg(st_q.slot[g].kind);
        assign done_vec[g] = st_q.slot[g].done;
        assign exc_vec[g]  = st_q.slot[g].exc;
        assign dst_vec[g]  = st_q.slot[g].dst;
        assign val_vec[g]  = st_q.slot[g].value;
    end

    rq_fwd #(
        .DEPTH(DEPTH), .AW(AW), .RW(RW), .XLEN(XLEN)
    ) u_fwd (
        .head_idx  (head_idx),
        .ent_valid (v_vec),
        .ent_wr    (wr_vec),
        .ent_done  (done_vec),
        .ent_exc   (exc_vec),
        .ent_dst   (dst_vec),
        .ent_value (val_vec),
        .src       (fwd_src),
        .req_idx   (fwd_req_idx),
        .hit       (fwd_hit),
        .value     (fwd_value)
    );

    assign alloc_ready  = !full_q && !trap;
    assign alloc_idx    = tail_idx;
    assign retire_valid = commit_ok;
    assign trap_valid   = trap;
    assign redirect_pc  = TRAP_VECTOR;
    assign take         = alloc_valid && alloc_ready;

    always_comb begin
        st_d = st_q;
        if (trap) begin
            // Kill the faulting slot and everything younger
            st_d.tail = st_q.head;
            for (int i = 0; i < DEPTH; i++) begin
                st_d.slot[i].valid = 1'b0;
            end
        end else begin
            if (commit_ok) begin
                st_d.slot[head_idx].valid = 1'b0;
                st_d.head                 = st_q.head + 1'b1;
            end
            if (take) begin
                st_d.slot[tail_idx].valid = 1'b1;
                st_d.slot[tail_idx].done  = 1'b0;
                st_d.slot[tail_idx].exc   = 1'b0;
                st_d.slot[tail_idx].kind  = kind_e'(alloc_kind);
                st_d.slot[tail_idx].dst   = alloc_dst;
                st_d.slot[tail_idx].pc    = alloc_pc;
                st_d.slot[tail_idx].value = '0;
                st_d.slot[tail_idx].cause = '0;
                st_d.tail                 = st_q.tail + 1'b1;
            end
            if (cpl_valid && st_q.slot[cpl_idx].valid) begin
                st_d.slot[cpl_idx].done  = 1'b1;
                st_d.slot[cpl_idx].exc   = cpl_exc;
                st_d.slot[cpl_idx].value = cpl_value;
                st_d.slot[cpl_idx].cause = cpl_cause;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Occupancy never exceeds capacity
    p_occupancy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_COUNT);

    // A trap leaves the queue empty on the next cycle
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (count_q == '0));

    // Trap is a single-cycle pulse
    p_trap_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !trap_valid);

    // Retirement moves the head by exactly one
    p_head_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |=> (st_q.head == $past(st_q.head) + 1'b1));

    // Clean retirement and trap never coincide, and a trap writes no register
    p_retire_trap_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retire_valid, trap_valid}) && !(trap_valid && rf_we));

    // Without retirement or trap the head holds still
    p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_valid && !trap_valid) |=> $stable(st_q.head));
endmodule

// File: tb/sim_retire_queue.sv
module sim_retire_queue;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int AW         = 3;
    localparam int RW         = 5;
    localparam int XLEN       = 32;
    localparam int WATCHDOG   = 5000;
    localparam logic [31:0] VEC_HANDLER = 32'h0000_0100;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             alloc_valid;
    logic [31:0]      alloc_pc;
    logic [1:0]       alloc_kind;
    logic [RW-1:0]    alloc_dst;
    logic             alloc_ready;
    logic [AW-1:0]    alloc_idx;
    logic             cpl_valid;
    logic [AW-1:0]    cpl_idx;
    logic [XLEN-1:0]  cpl_value;
    logic             cpl_exc;
    logic [3:0]       cpl_cause;
    logic [RW-1:0]    fwd_src;
    logic [AW-1:0]    fwd_req_idx;
    logic             fwd_hit;
    logic [XLEN-1:0]  fwd_value;
    logic             rf_we;
    logic [RW-1:0]    rf_waddr;
    logic [XLEN-1:0]  rf_wdata;
    logic             retire_valid;
    logic             trap_valid;
    logic [31:0]      trap_pc;
    logic [3:0]       trap_cause;
    logic [31:0]      redirect_pc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    retire_queue u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_kind(alloc_kind),
        .alloc_dst(alloc_dst), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .cpl_valid(cpl_valid), .cpl_idx(cpl_idx), .cpl_value(cpl_value),
        .cpl_exc(cpl_exc), .cpl_cause(cpl_cause),
        .fwd_src(fwd_src), .fwd_req_idx(fwd_req_idx), .fwd_hit(fwd_hit),
        .fwd_value(fwd_value),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .retire_valid(retire_valid), .trap_valid(trap_valid),
        .trap_pc(trap_pc), .trap_cause(trap_cause), .redirect_pc(redirect_pc)
    );

    // Program rows: {kind[1:0], dst[4:0], value[31:0]}
    localparam logic [38:0] PROG [DEPTH] = '{
        {2'd0, 5'd3,  32'h1111_0000},
        {2'd1, 5'd5,  32'h2222_0001},
        {2'd2, 5'd3,  32'h3333_0002},
        {2'd0, 5'd5,  32'h4444_0003},
        {2'd3, 5'd0,  32'h5555_0004},
        {2'd0, 5'd3,  32'h6666_0005},
        {2'd1, 5'd7,  32'h7777_0006},
        {2'd0, 5'd5,  32'h8888_0007}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        alloc_valid = 1'b0; alloc_pc = '0; alloc_kind = '0; alloc_dst = '0;
        cpl_valid = 1'b0; cpl_idx = '0; cpl_value = '0; cpl_exc = 1'b0; cpl_cause = '0;
        fwd_src = '0; fwd_req_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "alloc_ready", 64'(alloc_ready), 64'd1);
        chk("R1", "alloc_idx", 64'(alloc_idx), 64'd0);
        chk("R1", "retire_valid", 64'(retire_valid), 64'd0);
        chk("R1", "rf_we", 64'(rf_we), 64'd0);
        chk("R1", "trap_valid", 64'(trap_valid), 64'd0);

        // R2 allocate every row in program order
        for (int i = 0; i < DEPTH; i++) begin
            alloc_valid = 1'b1;
            alloc_kind  = PROG[i][38:37];
            alloc_dst   = PROG[i][36:32];
            alloc_pc    = 32'h1000 + 32'(4 * i);
            chk("R2", "alloc_idx", 64'(alloc_idx), 64'(i));
            chk("R2", "alloc_ready", 64'(alloc_ready), 64'd1);
            tick();
        end
        // R3 full: request refused
        alloc_kind = 2'd0; alloc_dst = 5'd9; alloc_pc = 32'hDEAD;
        chk("R3", "alloc_ready when full", 64'(alloc_ready), 64'd0);
        tick();
        alloc_valid = 1'b0;
        chk("R3", "alloc_ready stays low", 64'(alloc_ready), 64'd0);

        // R5 complete younger slots in reverse order; head stays unfinished
        for (int j = DEPTH - 1; j >= 1; j--) begin
            cpl_valid = 1'b1; cpl_idx = AW'(j); cpl_value = PROG[j][31:0];
            cpl_exc = 1'b0; cpl_cause = '0;
            tick();
            chk("R5", "no retire behind open head", 64'(retire_valid), 64'd0);
            chk("R5", "no rf write behind open head", 64'(rf_we), 64'd0);
        end
        cpl_valid = 1'b0;

        // R9 / R10 forwarding on a full queue
        fwd_src = 5'd5; fwd_req_idx = 3'd7; #1;
        chk("R9", "hit reg5 req7", 64'(fwd_hit), 64'd1);
        chk("R9", "value reg5 req7 youngest", 64'(fwd_value), 64'h4444_0003);
        fwd_src = 5'd3; fwd_req_idx = 3'd7; #1;
        chk("R9", "value reg3 req7 skips store", 64'(fwd_value), 64'h6666_0005);
        fwd_src = 5'd3; fwd_req_idx = 3'd5; #1;
        chk("R9", "producer not finished -> miss", 64'(fwd_hit), 64'd0);
        fwd_src = 5'd7; fwd_req_idx = 3'd6; #1;
        chk("R10", "own slot not matched", 64'(fwd_hit), 64'd0);
        fwd_src = 5'd9; fwd_req_idx = 3'd7; #1;
        chk("R10", "no producer -> miss", 64'(fwd_hit), 64'd0);
        fwd_src = 5'd0; fwd_req_idx = 3'd7; #1;
        chk("R10", "branch slot not matched", 64'(fwd_hit), 64'd0);

        // R4 release the head; table walk of in-order retirement
        cpl_valid = 1'b1; cpl_idx = 3'd0; cpl_value = PROG[0][31:0];
        tick();
        cpl_valid = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            logic w;
            w = (PROG[i][38:37] < 2'd2);
            chk("R11", "retire each cycle", 64'(retire_valid), 64'd1);
            chk("R6", "rf_we by kind", 64'(rf_we), 64'(w));
            if (w) begin
                chk("R6", "rf_waddr", 64'(rf_waddr), 64'(PROG[i][36:32]));
                chk("R4", "rf_wdata held", 64'(rf_wdata), 64'(PROG[i][31:0]));
            end
            tick();
        end
        chk("R5", "empty: no retire", 64'(retire_valid), 64'd0);
        chk("R2", "index wraps", 64'(alloc_idx), 64'd0);
        chk("R3", "space after drain", 64'(alloc_ready), 64'd1);

        // Trap scenario: slots 0..3
        for (int i = 0; i < 4; i++) begin
            alloc_valid = 1'b1; alloc_kind = 2'd0;
            alloc_dst = RW'(i + 1); alloc_pc = 32'h2000 + 32'(4 * i);
            tick();
        end
        alloc_valid = 1'b0;
        cpl_valid = 1'b1; cpl_idx = 3'd1; cpl_value = 32'hBAD; cpl_exc = 1'b1; cpl_cause = 4'd5;
        tick();
        chk("R7", "no trap off head", 64'(trap_valid), 64'd0);
        cpl_exc = 1'b0; cpl_cause = '0;
        cpl_idx = 3'd3; cpl_value = 32'h3333; tick();
        cpl_idx = 3'd2; cpl_value = 32'h2222; tick();
        cpl_idx = 3'd0; cpl_value = 32'hAAAA; tick();
        cpl_valid = 1'b0;
        chk("R6", "older retires first", 64'(rf_we), 64'd1);
        chk("R6", "older waddr", 64'(rf_waddr), 64'd1);
        chk("R6", "older wdata", 64'(rf_wdata), 64'hAAAA);
        chk("R7", "no trap yet", 64'(trap_valid), 64'd0);
        tick();
        chk("R7", "trap_valid", 64'(trap_valid), 64'd1);
        chk("R7", "trap_pc", 64'(trap_pc), 64'h2004);
        chk("R7", "trap_cause", 64'(trap_cause), 64'd5);
        chk("R7", "redirect_pc", 64'(redirect_pc), 64'(VEC_HANDLER));
        chk("R7", "no rf write on trap", 64'(rf_we), 64'd0);
        chk("R7", "no clean retire on trap", 64'(retire_valid), 64'd0);
        tick();
        chk("R7", "trap one cycle", 64'(trap_valid), 64'd0);
        chk("R8", "killed slots do not retire", 64'(retire_valid), 64'd0);
        chk("R8", "tail back to faulting slot", 64'(alloc_idx), 64'd1);
        fwd_src = 5'd3; fwd_req_idx = 3'd1; #1;
        chk("R10", "flushed producer not forwarded", 64'(fwd_hit), 64'd0);

        // R8 the whole capacity is free again
        for (int i = 0; i < DEPTH; i++) begin
            alloc_valid = 1'b1; alloc_kind = 2'd1; alloc_dst = 5'd4;
            alloc_pc = 32'h3000 + 32'(4 * i);
            chk("R8", "capacity restored", 64'(alloc_ready), 64'd1);
            tick();
        end
        alloc_valid = 1'b0;
        chk("R3", "full again", 64'(alloc_ready), 64'd0);
        chk("R8", "fresh slots not finished", 64'(retire_valid), 64'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule